// File: doc/BRIEF.md
# Link-Mode Packet Egress Transmitter with Port Polling

This block drives a packet egress bus toward an attached device. It runs in link mode and serves up to 64 logical ports. A free-running poll counter presents one port address per cycle on `poll_addr`. The attached device answers on `poll_status` one cycle later, and the block keeps the answers in a per-port ready map. When the transmitter is idle, an arbiter picks an eligible port. The block then sends one packet fragment: an address cycle carrying the port number, the data words pulled from a word source, and a final word marked end-of-packet with a 2-bit byte count. The word source presents, for the port shown on `src_port`, the next word of that port's current fragment, and it advances when `src_rd` is high. It always has a word ready for any port whose request bit is set.

Configuration arrives through a write-only register port with three addresses: 0 is global control, 1 is per-port setup, and 2 is test injection. Each field's bit position is given in the requirement that uses it. Optional padding can be switched on. Two modes set when a port may send: it can follow the latest polled status, or it can spend a one-fragment credit that only a fresh poll renews. For test, a single address parity error and a single data parity error can be forced on a chosen port. Each clears itself once used.

Top module: `spi3_egress_link_tx`

## Requirements
- R1: `poll_addr` is 0 after reset. It advances by one each cycle and returns to 0 after reaching poll length minus one. Poll length is control bits [5:0], resets to 15, and a value of 0 means 64. The answer on `poll_status` in the cycle after an address is shown is stored as that port's status.
- R2: After reset, every port is disabled and the bus is idle: `tx_enb`, `tx_sx` and `src_rd` are all 0.
- R3: A fragment is one address cycle (`tx_enb`=1, `tx_sx`=1, `tx_dat`=port number, zero-extended), followed at once by one data cycle per source word (`tx_enb`=1, `src_rd`=1). The last data cycle carries `tx_eop`=1 and `tx_mod` equal to `src_mod`. When the transmitter is ready to start another fragment, it first spends one idle cycle.
- R4: When control bit 8 is set, exactly two idle cycles follow each address cycle before the first data word. When it is clear, no cycles are added.
- R5: When control bit 9 is set, exactly two idle cycles follow each end-of-packet cycle, ahead of the usual idle cycle. When it is clear, no cycles are added.
- R6: A port is served only when its enable bit is set. Enable is port-register bit 8, and the port number is in bits [5:0]. A disabled port that has a request is skipped, but its poll slot remains in the sequence.
- R7: Status mode (control bit 12 clear): a requesting, enabled port starts fragments only while its last polled status is ready. It keeps being served back to back for as long as that status stays ready.
- R8: Credit mode (control bit 12 set): after a port sends one fragment, it is blocked. It is released only by a poll answer of ready for that port that is taken after the fragment's end-of-packet cycle.
- R9: When control bit 13 is clear, the search for the next port starts after the port served last, so two requesting ports alternate. When bit 13 is set, the search starts at the port served last, so one port can send several fragments in a row.
- R10: `tx_prty` gives odd parity over `tx_dat` on every cycle where `tx_enb` is high.
- R11: Test-register bit 8 inverts the parity of exactly one address cycle: the next one whose port number equals test bits [7:0]. The bit then clears itself. Other ports are not affected.
- R12: Test-register bit 9 inverts the parity of exactly one data word: the first data word of the next fragment sent to the port in test bits [7:0]. The bit then clears itself.
- R13: Port-register bit 9 reverses the bit order within each byte of that port's data words. Parity is computed on the reversed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 port setup, 2 test |
| cfg_wdata | input | 32 | Register write data |
| poll_addr | output | 6 | Port address being polled |
| poll_status | input | 1 | Device answer for the address shown one cycle earlier |
| port_req | input | NUM_PORTS | Per-port fragment pending |
| src_port | output | 6 | Port whose words the source must present |
| src_rd | output | 1 | Current source word is consumed |
| src_data | input | 32 | Source word |
| src_eop | input | 1 | Source word is the fragment's last |
| src_mod | input | 2 | Valid-byte code for the last word |
| tx_enb | output | 1 | Bus cycle carries an address or a data word |
| tx_sx | output | 1 | Address cycle marker |
| tx_eop | output | 1 | End-of-packet marker |
| tx_mod | output | 2 | Valid-byte code on the end-of-packet word |
| tx_dat | output | 32 | Bus data |
| tx_prty | output | 1 | Odd parity of `tx_dat` |

## Verification
The bus outputs are combinational from the transmit state, so each bus cycle is visible in the same cycle as its state. After the address cycle, the first data word appears one cycle later, or three cycles later with address padding. After an end-of-packet cycle, the next address cycle comes two cycles later, or four with end padding. A poll answer affects arbitration starting with the idle cycle after it is stored. The bench logs every bus cycle at the falling edge and checks these spacings by index distance from each logged address cycle, so it does not depend on absolute times. Where the bench is waiting for something not to happen, it checks over windows much longer than a full poll round.

// File: rtl/spi3e_pkg.sv
package spi3e_pkg;
  localparam int BUS_W  = 32;
  localparam int NBYTES = BUS_W / 8;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_STX,
    TX_SPAD,
    TX_DATA,
    TX_EPAD
  } tx_state_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_PORT = 2'd1;
  localparam logic [1:0] REG_TEST = 2'd2;

  localparam int CTRL_STXPAD = 8;
  localparam int CTRL_EOPPAD = 9;
  localparam int CTRL_CREDIT = 12;
  localparam int CTRL_MULTI  = 13;
  localparam int PORT_EN     = 8;
  localparam int PORT_BREV   = 9;
  localparam int TEST_ADDR   = 8;
  localparam int TEST_DATA   = 9;

  localparam int POLL_LEN_RST = 15;

  // mirror the bits inside every byte lane
  function automatic logic [BUS_W-1:0] byte_mirror(input logic [BUS_W-1:0] d);
    logic [BUS_W-1:0] r;
    for (int b = 0; b < NBYTES; b++) begin
      for (int i = 0; i < 8; i++) begin
        r[8*b+i] = d[8*b+7-i];
      end
    end
    return r;
  endfunction

  // parity bit that makes the total count of ones odd
  function automatic logic odd_fill(input logic [BUS_W-1:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/spi3e_poll.sv
module spi3e_poll #(
  parameter int NUM_PORTS = 64,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] poll_len,
  output logic [PW-1:0] poll_addr,
  input  logic          poll_status,
  output logic          smp_vld,
  output logic [PW-1:0] smp_port,
  output logic          smp_rdy
);
  logic [PW-1:0] last_slot;
  logic          at_end;

  assign last_slot = poll_len - 1'b1;
  assign at_end    = (poll_addr >= last_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_addr <= '0;
      smp_vld   <= 1'b0;
      smp_port  <= '0;
    end else begin
      poll_addr <= at_end ? '0 : poll_addr + 1'b1;
      smp_vld   <= 1'b1;
      smp_port  <= poll_addr;
    end
  end

  assign smp_rdy = poll_status;

  // R1: the poll address only steps by one or restarts at zero
  a_r1_poll_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> (poll_addr == smp_port + 1'b1) || (poll_addr == '0));
endmodule

// File: rtl/spi3e_arb.sv
module spi3e_arb #(
  parameter int NUM_PORTS = 64,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] elig,
  input  logic                 multi,
  input  logic                 done,
  input  logic [PW-1:0]        done_port,
  output logic                 gnt_vld,
  output logic [PW-1:0]        gnt_port
);
  logic [PW-1:0] last_q;
  int            start;

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= PW'(NUM_PORTS - 1);
    else if (done) last_q <= done_port;
  end

  always_comb begin
    start    = multi ? int'(last_q) : (int'(last_q) + 1) % NUM_PORTS;
    gnt_vld  = 1'b0;
    gnt_port = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      int idx;
      idx = (start + i) % NUM_PORTS;
      if (!gnt_vld && elig[idx]) begin
        gnt_vld  = 1'b1;
        gnt_port = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/spi3e_txfsm.sv
module spi3e_txfsm
  import spi3e_pkg::*;
#(
  parameter int NUM_PORTS = 64,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_vld,
  input  logic [PW-1:0]    gnt_port,
  input  logic             stx_pad,
  input  logic             eop_pad,
  input  logic             brev,
  input  logic             flip_addr,
  input  logic             flip_data,
  input  logic [BUS_W-1:0] src_data,
  input  logic             src_eop,
  input  logic [1:0]       src_mod,
  output logic [PW-1:0]    cur_port,
  output logic             src_rd,
  output logic             tx_enb,
  output logic             tx_sx,
  output logic             tx_eop,
  output logic [1:0]       tx_mod,
  output logic [BUS_W-1:0] tx_dat,
  output logic             tx_prty,
  output logic             stx_evt,
  output logic             first_evt,
  output logic             frag_done,
  output logic             flip_now
);
  tx_state_e st_q;
  logic      pad_q;
  logic      first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= TX_IDLE;
      pad_q    <= 1'b0;
      first_q  <= 1'b0;
      cur_port <= '0;
    end else begin
      case (st_q)
        TX_IDLE: if (gnt_vld) begin
          cur_port <= gnt_port;
          st_q     <= TX_STX;
        end
        TX_STX: begin
          first_q <= 1'b1;
          pad_q   <= 1'b0;
          st_q    <= stx_pad ? TX_SPAD : TX_DATA;
        end
        TX_SPAD: begin
          pad_q <= 1'b1;
          if (pad_q) st_q <= TX_DATA;
        end
        TX_DATA: begin
          first_q <= 1'b0;
          pad_q   <= 1'b0;
          if (src_eop) st_q <= eop_pad ? TX_EPAD : TX_IDLE;
        end
        TX_EPAD: begin
          pad_q <= 1'b1;
          if (pad_q) st_q <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign stx_evt   = (st_q == TX_STX);
  assign first_evt = (st_q == TX_DATA) && first_q;
  assign frag_done = (st_q == TX_DATA) && src_eop;
  assign src_rd    = (st_q == TX_DATA);
  assign flip_now  = (stx_evt && flip_addr) || (first_evt && flip_data);

  always_comb begin
    tx_enb = stx_evt || src_rd;
    tx_sx  = stx_evt;
    tx_eop = frag_done;
    tx_mod = src_rd ? src_mod : 2'b00;
    if (stx_evt)     tx_dat = BUS_W'(cur_port);
    else if (src_rd) tx_dat = brev ? byte_mirror(src_data) : src_data;
    else             tx_dat = '0;
    tx_prty = tx_enb ? (odd_fill(tx_dat) ^ flip_now) : 1'b0;
  end
endmodule

// File: rtl/spi3_egress_link_tx.sv
module spi3_egress_link_tx
  import spi3e_pkg::*;
#(
  parameter int NUM_PORTS = 64,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [PW-1:0]        poll_addr,
  input  logic                 poll_status,
  input  logic [NUM_PORTS-1:0] port_req,
  output logic [PW-1:0]        src_port,
  output logic                 src_rd,
  input  logic [BUS_W-1:0]     src_data,
  input  logic                 src_eop,
  input  logic [1:0]           src_mod,
  output logic                 tx_enb,
  output logic                 tx_sx,
  output logic                 tx_eop,
  output logic [1:0]           tx_mod,
  output logic [BUS_W-1:0]     tx_dat,
  output logic                 tx_prty
);
  logic [PW-1:0]        poll_len_q;
  logic                 stx_pad_q, eop_pad_q, credit_q, multi_q;
  logic [NUM_PORTS-1:0] en_q, brev_q, ready_q, credit_ok_q, elig;
  logic [7:0]           inj_port_q;
  logic                 inj_a_q, inj_d_q;

  logic                 smp_vld, smp_rdy;
  logic [PW-1:0]        smp_port;
  logic                 gnt_vld;
  logic [PW-1:0]        gnt_port, cur_port;
  logic                 stx_evt, first_evt, frag_done, flip_now;
  logic                 inj_hit, wr_ctrl, wr_port, wr_test;

  assign wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
  assign wr_port = cfg_we && (cfg_addr == REG_PORT);
  assign wr_test = cfg_we && (cfg_addr == REG_TEST);
  assign inj_hit = (inj_port_q == 8'(cur_port));

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_len_q <= PW'(POLL_LEN_RST);
      stx_pad_q  <= 1'b0;
      eop_pad_q  <= 1'b0;
      credit_q   <= 1'b0;
      multi_q    <= 1'b0;
      en_q       <= '0;
      brev_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        poll_len_q <= cfg_wdata[PW-1:0];
        stx_pad_q  <= cfg_wdata[CTRL_STXPAD];
        eop_pad_q  <= cfg_wdata[CTRL_EOPPAD];
        credit_q   <= cfg_wdata[CTRL_CREDIT];
        multi_q    <= cfg_wdata[CTRL_MULTI];
      end
      if (wr_port) begin
        en_q[cfg_wdata[PW-1:0]]   <= cfg_wdata[PORT_EN];
        brev_q[cfg_wdata[PW-1:0]] <= cfg_wdata[PORT_BREV];
      end
    end
  end

  // one-shot parity injection, cleared once consumed
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_port_q <= '0;
      inj_a_q    <= 1'b0;
      inj_d_q    <= 1'b0;
    end else if (wr_test) begin
      inj_port_q <= cfg_wdata[7:0];
      inj_a_q    <= cfg_wdata[TEST_ADDR];
      inj_d_q    <= cfg_wdata[TEST_DATA];
    end else begin
      if (stx_evt && inj_hit)   inj_a_q <= 1'b0;
      if (first_evt && inj_hit) inj_d_q <= 1'b0;
    end
  end

  // polled status map and credit map
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= '0;
      credit_ok_q <= '0;
    end else begin
      if (smp_vld) begin
        ready_q[smp_port]     <= smp_rdy;
        credit_ok_q[smp_port] <= smp_rdy;
      end
      if (frag_done) credit_ok_q[cur_port] <= 1'b0;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_elig
    assign elig[p] = en_q[p] && port_req[p] && (credit_q ? credit_ok_q[p] : ready_q[p]);
  end

  spi3e_poll #(.NUM_PORTS(NUM_PORTS)) u_poll (
    .clk, .rst_n, .poll_len(poll_len_q), .poll_addr, .poll_status,
    .smp_vld, .smp_port, .smp_rdy
  );

  spi3e_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk, .rst_n, .elig, .multi(multi_q), .done(frag_done), .done_port(cur_port),
    .gnt_vld, .gnt_port
  );

  spi3e_txfsm #(.NUM_PORTS(NUM_PORTS)) u_fsm (
    .clk, .rst_n, .gnt_vld, .gnt_port,
    .stx_pad(stx_pad_q), .eop_pad(eop_pad_q), .brev(brev_q[cur_port]),
    .flip_addr(inj_a_q && inj_hit), .flip_data(inj_d_q && inj_hit),
    .src_data, .src_eop, .src_mod, .cur_port, .src_rd,
    .tx_enb, .tx_sx, .tx_eop, .tx_mod, .tx_dat, .tx_prty,
    .stx_evt, .first_evt, .frag_done, .flip_now
  );

  assign src_port = cur_port;

  // R3: words are consumed only on data cycles
  a_r3_rd_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |-> (tx_enb && !tx_sx));
  // R4: two quiet cycles after a padded address cycle
  a_r4_stx_pad1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sx && stx_pad_q) |=> !tx_enb);
  a_r4_stx_pad2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_sx, 2) && $past(stx_pad_q, 2)) |-> !tx_enb);
  // R5: two quiet cycles after a padded end-of-packet
  a_r5_eop_pad1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eop && eop_pad_q) |=> !tx_enb);
  a_r5_eop_pad2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_eop, 2) && $past(eop_pad_q, 2)) |-> !tx_enb);
  // R6: an address cycle only names an enabled port
  a_r6_port_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sx && !$past(cfg_we)) |-> en_q[tx_dat[PW-1:0]]);
  // R8: credit is spent by a finished fragment
  a_r8_credit_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_done && credit_q) |=> !credit_ok_q[$past(cur_port)]);
  // R10: odd parity unless an injection is active
  a_r10_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enb && !flip_now) |-> (^{tx_dat, tx_prty}));
  // R11: address injection clears after use
  a_r11_addr_once: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_evt && inj_a_q && inj_hit && !wr_test) |=> !inj_a_q);
  // R12: data injection clears after use
  a_r12_data_once: assert property (@(posedge clk) disable iff (!rst_n)
    (first_evt && inj_d_q && inj_hit && !wr_test) |=> !inj_d_q);
endmodule

// File: tb/spi3_egress_link_tx_tb.sv
module spi3_egress_link_tx_tb;
  import spi3e_pkg::*;
  localparam int NP = 64;
  localparam int PW = 6;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [PW-1:0] poll_addr, src_port, pa_d;
  logic poll_status, src_rd, src_eop;
  logic [NP-1:0] port_req;
  logic [NP-1:0] dev_rdy = '0;
  logic [31:0] src_data, tx_dat;
  logic [1:0] src_mod, tx_mod;
  logic tx_enb, tx_sx, tx_eop, tx_prty;

  int issued[NP];
  int doneq[NP];
  int wcnt[NP];
  int flen[NP];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4ns clk = ~clk;

  spi3_egress_link_tx #(.NUM_PORTS(NP)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .poll_addr, .poll_status,
    .port_req, .src_port, .src_rd, .src_data, .src_eop, .src_mod,
    .tx_enb, .tx_sx, .tx_eop, .tx_mod, .tx_dat, .tx_prty
  );

  function automatic logic [31:0] gen(int p, int w);
    return {8'h01, 8'hC0, 2'b00, 6'(p), 4'h0, 4'(w)};
  endfunction

  function automatic logic [31:0] rev8(logic [31:0] d);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[(k/8)*8 + (7 - k%8)] = d[k];
    return r;
  endfunction

  // device and word-source model
  always @(posedge clk) begin
    pa_d <= poll_addr;
    if (src_rd) begin
      if (src_eop) begin
        wcnt[src_port]  <= 0;
        doneq[src_port] <= doneq[src_port] + 1;
      end else begin
        wcnt[src_port] <= wcnt[src_port] + 1;
      end
    end
  end
  assign poll_status = dev_rdy[pa_d];
  assign src_data = gen(int'(src_port), wcnt[src_port]);
  assign src_eop  = (wcnt[src_port] == flen[src_port] - 1);
  assign src_mod  = 2'b10;
  always_comb begin
    for (int p = 0; p < NP; p++) port_req[p] = (issued[p] > doneq[p]);
  end

  // bus log, one entry per cycle
  logic l_enb[LOGN], l_sx[LOGN], l_eop[LOGN], l_pr[LOGN];
  logic [1:0] l_mod[LOGN];
  logic [31:0] l_dat[LOGN];
  int lcnt = 0;
  always @(negedge clk) begin
    if (lcnt < LOGN) begin
      l_enb[lcnt] <= tx_enb;
      l_sx[lcnt]  <= tx_sx;
      l_eop[lcnt] <= tx_eop;
      l_pr[lcnt]  <= tx_prty;
      l_mod[lcnt] <= tx_mod;
      l_dat[lcnt] <= tx_dat;
      lcnt <= lcnt + 1;
    end
  end

  function automatic int find_sx(int from, int n);
    int seen = 0;
    for (int i = from; i < lcnt; i++) begin
      if (l_sx[i]) begin
        if (seen == n) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  function automatic int cnt_sx(int from, int port);
    int c = 0;
    for (int i = from; i < lcnt; i++)
      if (l_sx[i] && (port < 0 || int'(l_dat[i]) == port)) c++;
    return c;
  endfunction

  function automatic bit odd_at(int i);
    return ^{l_dat[i], l_pr[i]};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_wr(logic [1:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctrl(int len, bit sp, bit ep, bit cr, bit mb);
    cfg_wr(REG_CTRL, 32'(len) | (32'(sp) << 8) | (32'(ep) << 9) | (32'(cr) << 12) | (32'(mb) << 13));
  endtask

  task automatic port_cfg(int p, bit en, bit br);
    cfg_wr(REG_PORT, 32'(p) | (32'(en) << 8) | (32'(br) << 9));
  endtask

  task automatic issue(int p, int len, int n);
    flen[p] = len;
    issued[p] = issued[p] + n;
  endtask

  // R2: reset state and a disabled port stays silent
  task automatic t_reset();
    int base;
    chk(tx_enb == 0, "R2", "tx_enb in reset", tx_enb, 0);
    chk(src_rd == 0, "R2", "src_rd in reset", src_rd, 0);
    chk(poll_addr == 0, "R1", "poll_addr in reset", poll_addr, 0);
    rst_n = 1'b1;
    base = lcnt;
    issue(0, 4, 1);
    run(60);
    chk(cnt_sx(base, -1) == 0, "R2", "address cycles with all ports disabled", cnt_sx(base, -1), 0);
  endtask

  // R1: poll order and wrap for several lengths
  task automatic poll_walk(int len, int cycles);
    int errs = 0;
    int mx = 0;
    int lim = (len == 0) ? 64 : len;
    for (int i = 0; i < cycles; i++) begin
      int prev = int'(poll_addr);
      @(negedge clk);
      if (int'(poll_addr) != ((prev >= lim - 1) ? 0 : prev + 1)) errs++;
      if (int'(poll_addr) > mx) mx = int'(poll_addr);
    end
    chk(errs == 0, "R1", "poll step errors", errs, 0);
    chk(mx == lim - 1, "R1", "highest poll address", mx, lim - 1);
  endtask

  task automatic t_poll();
    poll_walk(15, 40);
    ctrl(4, 0, 0, 0, 0);
    run(4);
    poll_walk(4, 20);
    ctrl(0, 0, 0, 0, 0);
    run(70);
    poll_walk(0, 140);
    ctrl(15, 0, 0, 0, 0);
    run(20);
  endtask

  // R3 R10: fragment format and parity
  task automatic t_basic();
    int base, s, perr;
    base = lcnt;
    port_cfg(0, 1, 0);
    run(40);
    s = find_sx(base, 0);
    chk(s >= 0, "R3", "address cycle found", s, 0);
    if (s >= 0) begin
      chk(l_enb[s] && l_dat[s] == 0, "R3", "address cycle port", l_dat[s], 0);
      perr = 0;
      for (int w = 0; w < 4; w++) begin
        chk(l_enb[s+1+w] && !l_sx[s+1+w] && l_dat[s+1+w] == gen(0, w), "R3", "data word",
            l_dat[s+1+w], gen(0, w));
        chk(l_eop[s+1+w] == (w == 3), "R3", "eop position", l_eop[s+1+w], w == 3);
      end
      for (int i = s; i <= s + 4; i++) if (!odd_at(i)) perr++;
      chk(perr == 0, "R10", "even-parity cycles", perr, 0);
      chk(l_mod[s+4] == 2'b10, "R3", "final word mod", l_mod[s+4], 2);
      chk(!l_enb[s+5], "R3", "idle after eop", l_enb[s+5], 0);
    end
    chk(cnt_sx(base, -1) == 1, "R3", "fragment count", cnt_sx(base, -1), 1);
  endtask

  // R4 R5: padding
  task automatic t_pads(bit pad);
    int base, s1, s2, d;
    ctrl(15, pad, pad, 0, 1);
    port_cfg(1, 1, 0);
    run(20);
    base = lcnt;
    issue(1, 2, 2);
    run(50);
    s1 = find_sx(base, 0);
    s2 = find_sx(base, 1);
    d = pad ? 3 : 1;
    if (s1 >= 0) begin
      chk(l_enb[s1+d] && !l_sx[s1+d] && l_dat[s1+d] == gen(1, 0), "R4", "first data offset",
          l_dat[s1+d], gen(1, 0));
      chk(!pad || (!l_enb[s1+1] && !l_enb[s1+2]), "R4", "address pad quiet", l_enb[s1+1], 0);
    end
    chk(s1 >= 0 && s2 - s1 == d + 1 + (pad ? 2 : 0) + 2, "R5", "fragment spacing",
        s2 - s1, d + 1 + (pad ? 2 : 0) + 2);
  endtask

  // R7: status mode follows the polled status
  task automatic t_status();
    int base;
    ctrl(15, 0, 0, 0, 0);
    dev_rdy[4] = 1'b0;
    port_cfg(4, 1, 0);
    run(20);
    base = lcnt;
    issue(4, 2, 1);
    run(50);
    chk(cnt_sx(base, 4) == 0, "R7", "port 4 sent while not ready", cnt_sx(base, 4), 0);
    dev_rdy[4] = 1'b1;
    run(40);
    chk(cnt_sx(base, 4) == 1, "R7", "port 4 sent after ready", cnt_sx(base, 4), 1);
  endtask

  // R6: disabled port skipped until enabled
  task automatic t_disabled();
    int base;
    base = lcnt;
    issue(5, 2, 1);
    run(50);
    chk(cnt_sx(base, 5) == 0, "R6", "disabled port 5 sent", cnt_sx(base, 5), 0);
    port_cfg(5, 1, 0);
    run(30);
    chk(cnt_sx(base, 5) == 1, "R6", "enabled port 5 sent", cnt_sx(base, 5), 1);
  endtask

  // R13: per-byte bit reversal
  task automatic t_bitrev();
    int base, s;
    port_cfg(2, 1, 1);
    base = lcnt;
    issue(2, 2, 1);
    run(30);
    s = find_sx(base, 0);
    chk(s >= 0, "R13", "address cycle found", s, 0);
    if (s >= 0) begin
      for (int w = 0; w < 2; w++) begin
        chk(l_dat[s+1+w] == rev8(gen(2, w)), "R13", "mirrored word", l_dat[s+1+w], rev8(gen(2, w)));
        chk(odd_at(s+1+w), "R13", "parity on mirrored word", l_pr[s+1+w], ~l_pr[s+1+w]);
      end
    end
  endtask

  // R11 R12: one-shot parity injection
  task automatic t_inject();
    int base, s, s2;
    port_cfg(3, 1, 0);
    port_cfg(6, 1, 0);
    cfg_wr(REG_TEST, 32'h0000_0306);
    base = lcnt;
    issue(3, 2, 1);
    run(30);
    s = find_sx(base, 0);
    if (s >= 0)
      chk(odd_at(s) && odd_at(s+1) && odd_at(s+2), "R11", "other port untouched", l_pr[s], ~l_pr[s]);
    else chk(0, "R11", "port 3 fragment missing", s, 0);
    base = lcnt;
    issue(6, 2, 2);
    run(50);
    s = find_sx(base, 0);
    s2 = find_sx(base, 1);
    if (s >= 0 && s2 >= 0) begin
      chk(!odd_at(s), "R11", "first address parity inverted", l_pr[s], ~l_pr[s]);
      chk(odd_at(s2), "R11", "second address parity restored", l_pr[s2], ~l_pr[s2]);
      chk(!odd_at(s+1), "R12", "first data parity inverted", l_pr[s+1], ~l_pr[s+1]);
      chk(odd_at(s+2) && odd_at(s2+1) && odd_at(s2+2), "R12", "later data parity", l_pr[s+2], ~l_pr[s+2]);
    end else chk(0, "R11", "port 6 fragments missing", s2, 0);
  endtask

  // R9: rotation versus repeat
  task automatic t_multi(bit mb);
    int base;
    int pr[4];
    ctrl(15, 0, 0, 0, mb);
    port_cfg(7, 1, 0);
    port_cfg(8, 1, 0);
    run(20);
    base = lcnt;
    issue(7, 1, 2);
    issue(8, 1, 2);
    run(40);
    for (int i = 0; i < 4; i++) begin
      int s = find_sx(base, i);
      pr[i] = (s >= 0) ? int'(l_dat[s]) : -1;
    end
    if (mb)
      chk(pr[0] == pr[1] && pr[2] == pr[3] && pr[1] != pr[2] && pr[3] >= 0, "R9",
          "repeat order", pr[1], pr[0]);
    else
      chk(pr[0] != pr[1] && pr[1] != pr[2] && pr[2] != pr[3] && pr[3] >= 0, "R9",
          "alternating order", pr[1], pr[2]);
  endtask

  // R8: credit mode needs a fresh poll
  task automatic t_credit();
    int base, guard;
    ctrl(15, 0, 0, 1, 0);
    port_cfg(9, 1, 0);
    run(20);
    base = lcnt;
    issue(9, 4, 2);
    guard = 0;
    while (!tx_sx && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    ctrl(1, 0, 0, 1, 0);
    run(80);
    chk(cnt_sx(base, 9) == 1, "R8", "fragments without fresh poll", cnt_sx(base, 9), 1);
    ctrl(15, 0, 0, 1, 0);
    run(40);
    chk(cnt_sx(base, 9) == 2, "R8", "fragments after fresh poll", cnt_sx(base, 9), 2);
    ctrl(15, 0, 0, 0, 0);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) flen[p] = 1;
    dev_rdy = '1;
    repeat (5) @(negedge clk);
    t_reset();
    t_poll();
    t_basic();
    t_pads(0);
    t_pads(1);
    t_status();
    t_disabled();
    t_bitrev();
    t_inject();
    t_multi(0);
    t_multi(1);
    t_credit();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule